// File: doc/BRIEF.md
# CAN Message Object Status Bank

This block keeps the control and status flags of a bank of CAN message objects and updates them when the message handler stores a received frame, when a transmission completes, or when the CPU writes an object. Each object holds the following state:

- a new-data flag, a lost-message flag, an interrupt-pending flag and a transmit-request flag;
- a 4-bit data length code;
- three enables: receive-interrupt, transmit-interrupt and remote-answer.

The handler, the transmit engine and the CPU each have their own single-cycle strobe with an object index. Events for different objects in the same cycle are applied independently.

All per-object flags and length codes are brought out as flat vectors. A combined interrupt line is the OR of every pending flag. An index output names the lowest-numbered object that has a pending interrupt. Bus reception, bit timing and storage of the data bytes are handled elsewhere.

Top module: `msg_obj_status_bank`

## Requirements
- R1: After reset every flag, every length code and every enable is zero, `irq` is 0 and `irq_idx` is 0.
- R2: A data store (`st_valid`=1, `st_remote`=0) sets the addressed object's new-data flag and replaces its length code with `st_dlc` unchanged, including the values 9 to 15.
- R3: A data store into an object whose new-data flag is already 1 sets its lost-message flag. A data store into an object whose new-data flag is 0 leaves the lost-message flag as it was.
- R4: Any store (data or remote) sets the object's interrupt-pending flag when its receive-interrupt enable is 1, and leaves that flag unchanged when the enable is 0.
- R5: `tx_done` clears the addressed object's transmit request. It sets the object's interrupt-pending flag only when its transmit-interrupt enable is 1.
- R6: A remote store (`st_remote`=1) sets the transmit request when the object's remote-answer enable is 1, and leaves it unchanged otherwise. It changes neither the new-data flag nor the length code.
- R7: `cpu_wr` loads every field of the object selected by `cpu_idx` from `cpu_wdata` and leaves all other objects unchanged. The layout of `cpu_wdata` is: [3:0] length code, [4] transmit request, [5] interrupt pending, [6] lost message, [7] new data, [8] receive-interrupt enable, [9] transmit-interrupt enable, [10] remote-answer enable.
- R8: When a hardware set and a clear (by CPU write or by `tx_done`) hit the same flag of the same object in one cycle, the flag ends at 1. A data store also beats a CPU write to the length code.
- R9: `irq` is 1 exactly when some interrupt-pending flag is 1. `irq_idx` gives the lowest-numbered object with that flag set, and reads 0 when none is set.
- R10: A store, a `tx_done` and a CPU write that address three different objects in the same cycle all take effect.
- R11: All updates appear on the outputs one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Handler store strobe |
| st_idx | input | IDX_W | Object addressed by the store |
| st_dlc | input | 4 | Received length code |
| st_remote | input | 1 | Stored frame is a remote frame |
| tx_done | input | 1 | Transmission-complete strobe |
| tx_idx | input | IDX_W | Object whose transmission completed |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_idx | input | IDX_W | Object written by the CPU |
| cpu_wdata | input | 11 | Values for the written object (layout in R7) |
| new_dat | output | NUM_OBJ | New-data flag per object |
| msg_lost | output | NUM_OBJ | Lost-message flag per object |
| int_pend | output | NUM_OBJ | Interrupt-pending flag per object |
| tx_req | output | NUM_OBJ | Transmit-request flag per object |
| dlc | output | 4*NUM_OBJ | Length code per object, object i at [4i+3:4i] |
| irq | output | 1 | OR of all interrupt-pending flags |
| irq_idx | output | IDX_W | Lowest object with a pending interrupt |

## Verification
The hardest situation to reach is a collision on one object in a single cycle. One case is a data store landing together with a CPU write that clears the same flags. The other is a remote frame arriving together with the transmit-complete strobe for that object. The directed scenarios first program the enables through CPU writes. They then raise the colliding strobes on the same falling edge, so that both are sampled by one rising edge, and check that the set wins. A further scenario fires all three strobes at different objects at once.

// File: rtl/msg_obj_pkg.sv
`timescale 1ns/1ps
package msg_obj_pkg;

    localparam int LEN_W = 4;

    // CPU write word, MSB first: bit 10 down to bit 0
    typedef struct packed {
        logic             rmt_en;
        logic             tx_ie;
        logic             rx_ie;
        logic             new_dat;
        logic             msg_lost;
        logic             int_pend;
        logic             tx_req;
        logic [LEN_W-1:0] len;
    } obj_word_t;

    localparam int WORD_W = $bits(obj_word_t);

endpackage

// File: rtl/msg_obj_slot.sv
`timescale 1ns/1ps
module msg_obj_slot
    import msg_obj_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_hit,
    input  logic             st_remote,
    input  logic [LEN_W-1:0] st_dlc,
    input  logic             tx_hit,
    input  logic             cpu_hit,
    input  obj_word_t        cpu_word,
    output logic             new_dat,
    output logic             msg_lost,
    output logic             int_pend,
    output logic             tx_req,
    output logic [LEN_W-1:0] len
);

    logic rx_ie, tx_ie, rmt_en;
    logic data_st, rmt_st;
    logic nd_n, ml_n, ip_n, tr_n;
    logic [LEN_W-1:0] len_n;

    assign data_st = st_hit & ~st_remote;
    assign rmt_st  = st_hit &  st_remote;

    // CPU value first, then hardware clears, then hardware sets (sets win)
    always_comb begin
        nd_n  = cpu_hit ? cpu_word.new_dat  : new_dat;
        ml_n  = cpu_hit ? cpu_word.msg_lost : msg_lost;
        ip_n  = cpu_hit ? cpu_word.int_pend : int_pend;
        tr_n  = cpu_hit ? cpu_word.tx_req   : tx_req;
        len_n = cpu_hit ? cpu_word.len      : len;

        if (tx_hit) begin
            tr_n = 1'b0;
        end

        nd_n = nd_n | data_st;
        ml_n = ml_n | (data_st & new_dat);
        ip_n = ip_n | (st_hit & rx_ie) | (tx_hit & tx_ie);
        tr_n = tr_n | (rmt_st & rmt_en);

        if (data_st) begin
            len_n = st_dlc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_dat  <= 1'b0;
            msg_lost <= 1'b0;
            int_pend <= 1'b0;
            tx_req   <= 1'b0;
            len      <= '0;
            rx_ie    <= 1'b0;
            tx_ie    <= 1'b0;
            rmt_en   <= 1'b0;
        end else begin
            new_dat  <= nd_n;
            msg_lost <= ml_n;
            int_pend <= ip_n;
            tx_req   <= tr_n;
            len      <= len_n;
            if (cpu_hit) begin
                rx_ie  <= cpu_word.rx_ie;
                tx_ie  <= cpu_word.tx_ie;
                rmt_en <= cpu_word.rmt_en;
            end
        end
    end

endmodule

// File: rtl/msg_obj_prio_enc.sv
`timescale 1ns/1ps
module msg_obj_prio_enc #(
    parameter int NUM_OBJ = 8,
    localparam int IDX_W  = $clog2(NUM_OBJ)
) (
    input  logic [NUM_OBJ-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        idx = '0;
        for (int i = NUM_OBJ - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/msg_obj_status_bank.sv
`timescale 1ns/1ps
module msg_obj_status_bank
    import msg_obj_pkg::*;
#(
    parameter int NUM_OBJ = 8,
    localparam int IDX_W  = $clog2(NUM_OBJ)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     st_valid,
    input  logic [IDX_W-1:0]         st_idx,
    input  logic [LEN_W-1:0]         st_dlc,
    input  logic                     st_remote,
    input  logic                     tx_done,
    input  logic [IDX_W-1:0]         tx_idx,
    input  logic                     cpu_wr,
    input  logic [IDX_W-1:0]         cpu_idx,
    input  logic [WORD_W-1:0]        cpu_wdata,
    output logic [NUM_OBJ-1:0]       new_dat,
    output logic [NUM_OBJ-1:0]       msg_lost,
    output logic [NUM_OBJ-1:0]       int_pend,
    output logic [NUM_OBJ-1:0]       tx_req,
    output logic [LEN_W*NUM_OBJ-1:0] dlc,
    output logic                     irq,
    output logic [IDX_W-1:0]         irq_idx
);

    obj_word_t cpu_word;
    assign cpu_word = obj_word_t'(cpu_wdata);

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
        logic st_hit, tx_hit, cpu_hit;
        assign st_hit  = st_valid && (st_idx  == IDX_W'(g));
        assign tx_hit  = tx_done  && (tx_idx  == IDX_W'(g));
        assign cpu_hit = cpu_wr   && (cpu_idx == IDX_W'(g));

        msg_obj_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .st_hit    (st_hit),
            .st_remote (st_remote),
            .st_dlc    (st_dlc),
            .tx_hit    (tx_hit),
            .cpu_hit   (cpu_hit),
            .cpu_word  (cpu_word),
            .new_dat   (new_dat[g]),
            .msg_lost  (msg_lost[g]),
            .int_pend  (int_pend[g]),
            .tx_req    (tx_req[g]),
            .len       (dlc[g*LEN_W +: LEN_W])
        );
    end

    msg_obj_prio_enc #(.NUM_OBJ(NUM_OBJ)) u_prio (
        .req (int_pend),
        .any (irq),
        .idx (irq_idx)
    );

endmodule

// File: rtl/msg_obj_status_chk.sv
`timescale 1ns/1ps
module msg_obj_status_chk #(
    parameter int NUM_OBJ = 8,
    localparam int IDX_W  = $clog2(NUM_OBJ)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               st_valid,
    input logic [IDX_W-1:0]   st_idx,
    input logic               st_remote,
    input logic               tx_done,
    input logic [IDX_W-1:0]   tx_idx,
    input logic               cpu_wr,
    input logic [IDX_W-1:0]   cpu_idx,
    input logic [NUM_OBJ-1:0] new_dat,
    input logic [NUM_OBJ-1:0] msg_lost,
    input logic [NUM_OBJ-1:0] int_pend,
    input logic [NUM_OBJ-1:0] tx_req,
    input logic               irq,
    input logic [IDX_W-1:0]   irq_idx
);

    logic [IDX_W-1:0]   q_st_idx, q_tx_idx;
    logic [NUM_OBJ-1:0] below;

    always_ff @(posedge clk) begin
        q_st_idx <= st_idx;
        q_tx_idx <= tx_idx;
    end

    assign below = int_pend & ((NUM_OBJ'(1) << irq_idx) - NUM_OBJ'(1));

    p_store_sets_new_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_remote) |=> new_dat[q_st_idx]);

    p_overrun_lost_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_remote && new_dat[st_idx]) |=> msg_lost[q_st_idx]);

    p_done_clears_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !(st_valid && st_remote && st_idx == tx_idx)) |=> !tx_req[q_tx_idx]);

    p_set_beats_cpu_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_remote && cpu_wr && cpu_idx == st_idx) |=> new_dat[q_st_idx]);

    p_irq_points_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int_pend[irq_idx] && below == '0));

    p_idle_idx_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (irq_idx == '0 && int_pend == '0));

endmodule

bind msg_obj_status_bank msg_obj_status_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_idx    (st_idx),
    .st_remote (st_remote),
    .tx_done   (tx_done),
    .tx_idx    (tx_idx),
    .cpu_wr    (cpu_wr),
    .cpu_idx   (cpu_idx),
    .new_dat   (new_dat),
    .msg_lost  (msg_lost),
    .int_pend  (int_pend),
    .tx_req    (tx_req),
    .irq       (irq),
    .irq_idx   (irq_idx)
);

// File: tb/msg_obj_status_bank_test.sv
`timescale 1ns/1ps
module msg_obj_status_bank_test;

    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [IW-1:0] st_idx = '0;
    logic [3:0]    st_dlc = '0;
    logic          st_remote = 1'b0;
    logic          tx_done = 1'b0;
    logic [IW-1:0] tx_idx = '0;
    logic          cpu_wr = 1'b0;
    logic [IW-1:0] cpu_idx = '0;
    logic [10:0]   cpu_wdata = '0;
    logic [N-1:0]  new_dat, msg_lost, int_pend, tx_req;
    logic [4*N-1:0] dlc;
    logic          irq;
    logic [IW-1:0] irq_idx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    msg_obj_status_bank #(.NUM_OBJ(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_idx(st_idx), .st_dlc(st_dlc), .st_remote(st_remote),
        .tx_done(tx_done), .tx_idx(tx_idx),
        .cpu_wr(cpu_wr), .cpu_idx(cpu_idx), .cpu_wdata(cpu_wdata),
        .new_dat(new_dat), .msg_lost(msg_lost), .int_pend(int_pend), .tx_req(tx_req),
        .dlc(dlc), .irq(irq), .irq_idx(irq_idx)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // word: rmt_en, tx_ie, rx_ie, new_dat, msg_lost, int_pend, tx_req, dlc
    function automatic logic [10:0] word(input bit rmt, input bit txie, input bit rxie,
                                         input bit nd, input bit ml, input bit ip,
                                         input bit tr, input logic [3:0] len);
        return {rmt, txie, rxie, nd, ml, ip, tr, len};
    endfunction

    // drive strobes for one rising edge, then check at the following falling edge
    task automatic release_all();
        @(negedge clk);
        st_valid = 1'b0; tx_done = 1'b0; cpu_wr = 1'b0; st_remote = 1'b0;
    endtask

    task automatic cpu_write(input int idx, input logic [10:0] w);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_idx = IW'(idx); cpu_wdata = w;
        release_all();
    endtask

    task automatic store(input int idx, input bit rmt, input logic [3:0] len);
        @(negedge clk);
        st_valid = 1'b1; st_idx = IW'(idx); st_remote = rmt; st_dlc = len;
        release_all();
    endtask

    task automatic done(input int idx);
        @(negedge clk);
        tx_done = 1'b1; tx_idx = IW'(idx);
        release_all();
    endtask

    function automatic int len_of(input int i);
        return int'(dlc[i*4 +: 4]);
    endfunction

    task automatic t_reset();
        chk("R1 new_dat", int'(new_dat), 0);
        chk("R1 msg_lost", int'(msg_lost), 0);
        chk("R1 int_pend", int'(int_pend), 0);
        chk("R1 tx_req", int'(tx_req), 0);
        chk("R1 dlc", int'(dlc), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 irq_idx", int'(irq_idx), 0);
    endtask

    task automatic t_store();
        cpu_write(2, word(0, 0, 1, 0, 0, 0, 0, 4'd0));
        chk("R11 no irq yet", int'(irq), 0);
        store(2, 0, 4'd11);
        chk("R2 new_dat[2]", int'(new_dat[2]), 1);
        chk("R2 dlc[2] raw 11", len_of(2), 11);
        chk("R3 no loss first store", int'(msg_lost[2]), 0);
        chk("R4 int_pend[2] rx_ie=1", int'(int_pend[2]), 1);
        chk("R9 irq", int'(irq), 1);
        chk("R9 irq_idx", int'(irq_idx), 2);
    endtask

    task automatic t_lost();
        store(2, 0, 4'd3);
        chk("R3 msg_lost[2]", int'(msg_lost[2]), 1);
        chk("R2 dlc[2] replaced", len_of(2), 3);
        store(5, 0, 4'd6);
        chk("R4 int_pend[5] rx_ie=0", int'(int_pend[5]), 0);
        chk("R3 msg_lost[5] clean", int'(msg_lost[5]), 0);
        chk("R2 new_dat[5]", int'(new_dat[5]), 1);
    endtask

    task automatic t_cpu();
        cpu_write(2, word(0, 0, 1, 0, 0, 0, 0, 4'd0));
        chk("R7 new_dat[2] cleared", int'(new_dat[2]), 0);
        chk("R7 msg_lost[2] cleared", int'(msg_lost[2]), 0);
        chk("R7 int_pend[2] cleared", int'(int_pend[2]), 0);
        chk("R7 obj5 untouched", int'(new_dat[5]), 1);
        chk("R7 dlc[5] untouched", len_of(5), 6);
        chk("R9 irq idle", int'(irq), 0);
        chk("R9 irq_idx idle", int'(irq_idx), 0);
    endtask

    task automatic t_remote();
        cpu_write(1, word(1, 0, 0, 0, 0, 0, 0, 4'd0));
        cpu_write(3, word(0, 0, 0, 0, 0, 0, 0, 4'd0));
        store(1, 1, 4'd7);
        chk("R6 tx_req[1] rmt_en=1", int'(tx_req[1]), 1);
        chk("R6 new_dat[1] unchanged", int'(new_dat[1]), 0);
        chk("R6 dlc[1] unchanged", len_of(1), 0);
        store(3, 1, 4'd7);
        chk("R6 tx_req[3] rmt_en=0", int'(tx_req[3]), 0);
    endtask

    task automatic t_txdone();
        cpu_write(4, word(0, 1, 0, 0, 0, 0, 1, 4'd2));
        cpu_write(6, word(0, 0, 0, 0, 0, 0, 1, 4'd2));
        chk("R7 tx_req[4] loaded", int'(tx_req[4]), 1);
        done(4);
        chk("R5 tx_req[4] cleared", int'(tx_req[4]), 0);
        chk("R5 int_pend[4] tx_ie=1", int'(int_pend[4]), 1);
        done(6);
        chk("R5 tx_req[6] cleared", int'(tx_req[6]), 0);
        chk("R5 int_pend[6] tx_ie=0", int'(int_pend[6]), 0);
        chk("R9 idx 4", int'(irq_idx), 4);
        cpu_write(7, word(0, 0, 0, 0, 0, 1, 0, 4'd0));
        chk("R9 lowest wins", int'(irq_idx), 4);
        cpu_write(4, word(0, 1, 0, 0, 0, 0, 0, 4'd2));
        chk("R9 idx moves to 7", int'(irq_idx), 7);
        cpu_write(7, word(0, 0, 0, 0, 0, 0, 0, 4'd0));
        chk("R9 irq idle again", int'(irq), 0);
    endtask

    task automatic t_conflict();
        @(negedge clk);
        st_valid = 1'b1; st_idx = IW'(2); st_remote = 1'b0; st_dlc = 4'd5;
        cpu_wr = 1'b1; cpu_idx = IW'(2); cpu_wdata = word(0, 0, 1, 0, 0, 0, 0, 4'd9);
        release_all();
        chk("R8 new_dat[2] set wins", int'(new_dat[2]), 1);
        chk("R8 int_pend[2] set wins", int'(int_pend[2]), 1);
        chk("R8 dlc[2] store wins", len_of(2), 5);
        @(negedge clk);
        st_valid = 1'b1; st_idx = IW'(1); st_remote = 1'b1; st_dlc = 4'd0;
        tx_done = 1'b1; tx_idx = IW'(1);
        release_all();
        chk("R8 tx_req[1] remote beats done", int'(tx_req[1]), 1);
        chk("R8 int_pend[1] no enables", int'(int_pend[1]), 0);
    endtask

    task automatic t_parallel();
        @(negedge clk);
        st_valid = 1'b1; st_idx = IW'(0); st_remote = 1'b0; st_dlc = 4'd8;
        tx_done = 1'b1; tx_idx = IW'(3);
        cpu_wr = 1'b1; cpu_idx = IW'(5); cpu_wdata = word(0, 0, 0, 0, 1, 0, 0, 4'd7);
        release_all();
        chk("R10 new_dat[0]", int'(new_dat[0]), 1);
        chk("R10 dlc[0]", len_of(0), 8);
        chk("R10 msg_lost[5]", int'(msg_lost[5]), 1);
        chk("R10 new_dat[5]", int'(new_dat[5]), 0);
        chk("R10 dlc[5]", len_of(5), 7);
        chk("R10 tx_req[3]", int'(tx_req[3]), 0);
        chk("R10 obj2 untouched", int'(new_dat[2]), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store();
        t_lost();
        t_cpu();
        t_remote();
        t_txdone();
        t_conflict();
        t_parallel();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule